// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block turns an asynchronous serial line into parallel words. A sampling enable, `tick16`, pulses at sixteen times the bit rate. While the line idles at mark, the receiver waits for a falling edge. It then counts half a bit time and looks at the line again, so that a short glitch is dropped as a false start. After a valid start bit it samples every data bit near its centre, then the optional parity bit and the stop bits. The word is assembled in a shift register that moves toward the least significant end.

A completed word is placed in a single holding register. That register is presented on a valid/ready output. `m_valid` stays high, and `m_data` stays unchanged, until a cycle in which both `m_valid` and `m_ready` are high. That handshake empties the register. The serial line cannot be stalled, so back-pressure does not slow the receiver. A word that completes while the holding register is still full is dropped, and the overrun flag is raised. Four status flags report overrun, parity error, framing error and break. They hold until a one-cycle `stat_clr` pulse. Word length, parity mode and stop-bit count come from plain configuration pins, which are expected to stay steady while a frame is in flight.

Top module: `rx_frame_engine`

## Requirements
- R1: The line passes through a two-flop synchronizer. In idle the receiver leaves idle only on a high-to-low transition of the synchronized line. A line held low without a new falling edge starts no frame.
- R2: On the 8th tick after the falling edge the line is sampled again. A low level confirms the start bit. A high level is a false start: the receiver returns to idle and delivers no word.
- R3: After a valid start, one sample is taken every 16 ticks. The first data bit received lands in bit 0 of `m_data`. `cfg_wlen` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7, 11 gives 8. Unused upper bits of `m_data` are 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. Without stick parity (`cfg_par_stick` = 0), `cfg_par_even` = 1 expects an even count of ones over data and parity, and 0 expects an odd count. With stick parity, the parity bit must be 0 when `cfg_par_even` = 1 and 1 when it is 0. A mismatch sets `st_parity`.
- R5: A stop bit sampled low sets `st_framing`. When `cfg_stop2` = 1, a second stop bit is also sampled and checked the same way.
- R6: A frame whose every sample is low, from start bit through the last stop bit, sets `st_break` and `st_framing` and delivers the word 0.
- R7: A word loaded into the empty holding register raises `m_valid`. While `m_valid` is high and `m_ready` is low, `m_data` holds its value. A cycle with both high empties the register.
- R8: A word that completes while `m_valid` is high (and is not being read in that cycle) is discarded and sets `st_overrun`. The held word is kept.
- R9: The status flags stay set until `stat_clr` is pulsed. A read through the handshake does not clear them. If a new error arrives in the same cycle as `stat_clr`, the new error wins.
- R10: All bit timing counts `tick16` pulses only, so a slower tick stretches the bit time to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, high = mark |
| cfg_wlen | input | 2 | Word length code (00 = 5 bits … 11 = 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select (stick: expect 0) |
| cfg_par_stick | input | 1 | Stick (fixed-level) parity |
| cfg_stop2 | input | 1 | Check two stop bits |
| m_valid | output | 1 | Holding register full |
| m_ready | input | 1 | Consumer takes the held word |
| m_data | output | 8 | Received word, right aligned |
| stat_clr | input | 1 | Clear all status flags |
| st_overrun | output | 1 | A word was lost |
| st_parity | output | 1 | Parity mismatch seen |
| st_framing | output | 1 | Stop bit sampled low |
| st_break | output | 1 | All-space frame seen |

## Verification
Overrun is the hardest case to reach. It needs a second complete frame to finish while the first word is still held. The stimulus gets there by keeping `m_ready` low across two back-to-back frames, then checking that the first word and the overrun flag both survive. False start and break are reached by driving the line directly. For a false start, the line drops low for a few cycles, well under half a bit. For a break, it is held low for longer than a whole frame.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_t;

  typedef struct packed {
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_flags_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], rxd};
  end

  assign line = sh[STAGES-1];
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              fall,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_stop2,
  output logic              fr_valid,
  output logic [DATA_W-1:0] fr_data,
  output rx_flags_t         fr_flags
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int IW = $clog2(DATA_W);
  localparam int MIN_W = DATA_W - 3;
  localparam logic [CW-1:0] C_MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] C_FULL = CW'(OVERSAMPLE - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sreg;
  logic              par_acc, par_bad, frm_bad, all_low;

  logic [IW-1:0] last_idx;
  logic          at_mid, at_full, par_exp;
  logic [1:0]    shamt;

  assign last_idx = IW'(MIN_W - 1) + IW'(cfg_wlen);
  assign at_mid   = tick && (cnt == C_MID);
  assign at_full  = tick && (cnt == C_FULL);
  assign shamt    = 2'd3 - cfg_wlen;
  // expected parity bit given the data ones accumulated so far
  assign par_exp  = cfg_par_stick ? ~cfg_par_even
                                  : (cfg_par_even ? par_acc : ~par_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sreg     <= '0;
      par_acc  <= 1'b0;
      par_bad  <= 1'b0;
      frm_bad  <= 1'b0;
      all_low  <= 1'b0;
      fr_valid <= 1'b0;
      fr_data  <= '0;
      fr_flags <= '0;
    end else begin
      fr_valid <= 1'b0;
      if (st != S_IDLE && tick) cnt <= cnt + 1'b1;
      unique case (st)
        S_IDLE: begin
          if (fall) begin
            st      <= S_START;
            cnt     <= '0;
            idx     <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
            frm_bad <= 1'b0;
            all_low <= 1'b1;
            sreg    <= '0;
          end
        end
        S_START: begin
          if (at_mid) begin
            cnt <= '0;
            st  <= line ? S_IDLE : S_DATA;
          end
        end
        S_DATA: begin
          if (at_full) begin
            cnt     <= '0;
            sreg    <= {line, sreg[DATA_W-1:1]};
            par_acc <= par_acc ^ line;
            all_low <= all_low & ~line;
            idx     <= idx + 1'b1;
            if (idx == last_idx) st <= cfg_par_en ? S_PAR : S_STOP1;
          end
        end
        S_PAR: begin
          if (at_full) begin
            cnt     <= '0;
            par_bad <= (line != par_exp);
            all_low <= all_low & ~line;
            st      <= S_STOP1;
          end
        end
        S_STOP1: begin
          if (at_full) begin
            cnt     <= '0;
            frm_bad <= ~line;
            all_low <= all_low & ~line;
            if (cfg_stop2) st <= S_STOP2;
            else begin
              st            <= S_IDLE;
              fr_valid      <= 1'b1;
              fr_data       <= sreg >> shamt;
              fr_flags.perr <= par_bad;
              fr_flags.ferr <= ~line;
              fr_flags.brk  <= all_low & ~line;
            end
          end
        end
        S_STOP2: begin
          if (at_full) begin
            cnt           <= '0;
            st            <= S_IDLE;
            fr_valid      <= 1'b1;
            fr_data       <= sreg >> shamt;
            fr_flags.perr <= par_bad;
            fr_flags.ferr <= frm_bad | ~line;
            fr_flags.brk  <= all_low & ~line;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: idle is left only through a falling edge
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !fall) |=> st == S_IDLE);

  // R2: a high level at the half-bit check aborts the frame
  assert_false_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && at_mid && line) |=> (st == S_IDLE && !fr_valid));

  // R10: the bit counter moves only on a tick while a frame is open
  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !tick && $past(st) != S_IDLE) |=> $stable(cnt));
endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  input  logic [DATA_W-1:0] fr_data,
  input  rx_flags_t         fr_flags,
  input  logic              m_ready,
  input  logic              stat_clr,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              st_overrun,
  output logic              st_parity,
  output logic              st_framing,
  output logic              st_break
);
  logic take, load, lose;

  assign take = m_valid & m_ready;
  assign load = fr_valid & (~m_valid | take);
  assign lose = fr_valid & m_valid & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid    <= 1'b0;
      m_data     <= '0;
      st_overrun <= 1'b0;
      st_parity  <= 1'b0;
      st_framing <= 1'b0;
      st_break   <= 1'b0;
    end else begin
      if (load) begin
        m_valid <= 1'b1;
        m_data  <= fr_data;
      end else if (take) begin
        m_valid <= 1'b0;
      end
      st_overrun <= (st_overrun & ~stat_clr) | lose;
      st_parity  <= (st_parity  & ~stat_clr) | (load & fr_flags.perr);
      st_framing <= (st_framing & ~stat_clr) | (load & fr_flags.ferr);
      st_break   <= (st_break   & ~stat_clr) | (load & fr_flags.brk);
    end
  end

  // R7: held word is stable under back-pressure
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R8: overrun can only appear while a word was held
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $past(m_valid));

  // R9: flags persist without a clear
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_parity && !stat_clr) |=> st_parity);
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_stop2,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic              stat_clr,
  output logic              st_overrun,
  output logic              st_parity,
  output logic              st_framing,
  output logic              st_break
);
  logic              line, fall, fr_valid;
  logic [DATA_W-1:0] fr_data;
  rx_flags_t         fr_flags;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line), .fall(fall)
  );

  rx_bit_sampler #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line), .fall(fall),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
    .cfg_stop2(cfg_stop2), .fr_valid(fr_valid), .fr_data(fr_data),
    .fr_flags(fr_flags)
  );

  rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_data(fr_data),
    .fr_flags(fr_flags), .m_ready(m_ready), .stat_clr(stat_clr),
    .m_valid(m_valid), .m_data(m_data), .st_overrun(st_overrun),
    .st_parity(st_parity), .st_framing(st_framing), .st_break(st_break)
  );
endmodule

// File: tb/rx_frame_engine_bench.sv
module rx_frame_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'b11;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0, cfg_stop2 = 1'b0;
  logic m_ready = 1'b0, stat_clr = 1'b0;
  logic m_valid, st_overrun, st_parity, st_framing, st_break;
  logic [7:0] m_data;
  logic tick16;
  int tdiv = 1;
  int tcnt = 0;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  always @(negedge clk) tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
  assign tick16 = (tcnt == 0);

  rx_frame_engine u_rx_frame_engine (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_stop2(cfg_stop2),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .stat_clr(stat_clr), .st_overrun(st_overrun), .st_parity(st_parity),
    .st_framing(st_framing), .st_break(st_break)
  );

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] wl;
    logic pen, pev, pst, st2, flip, s1, s2;
    logic [7:0] ed;
    logic epe, efe;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},
    '{8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    '{8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0},
    '{8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h1F, 1'b0, 1'b0},
    '{8'h55, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0},
    '{8'h55, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0},
    '{8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
    '{8'hCF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F, 1'b0, 1'b1},
    '{8'h6B, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h6B, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input int nb,
                                   input logic ev, input logic stk);
    logic ones = 1'b0;
    for (int i = 0; i < nb; i++) ones ^= d[i];
    if (stk) return ~ev;
    return ev ? ones : ~ones;
  endfunction

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (16 * tdiv) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip,
                      input logic s1, input logic s2);
    int nb = 5 + int'(cfg_wlen);
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (cfg_par_en) bit_out(par_bit(d, nb, cfg_par_even, cfg_par_stick) ^ flip);
    bit_out(s1);
    if (cfg_stop2) bit_out(s2);
    rxd = 1'b1;
    repeat (32 * tdiv) @(negedge clk);
  endtask

  task automatic pulse_ready();
    m_ready = 1'b1; @(negedge clk); m_ready = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R7 reset valid", m_valid, 0);
    chk("R9 reset flags", {st_overrun, st_parity, st_framing, st_break}, 0);

    // table of frames: R3 R4 R5
    for (int k = 0; k < 9; k++) begin
      cfg_wlen = VEC[k].wl; cfg_par_en = VEC[k].pen; cfg_par_even = VEC[k].pev;
      cfg_par_stick = VEC[k].pst; cfg_stop2 = VEC[k].st2;
      send(VEC[k].d, VEC[k].flip, VEC[k].s1, VEC[k].s2);
      chk($sformatf("R7 vec%0d valid", k), m_valid, 1);
      chk($sformatf("R3 vec%0d data", k), m_data, VEC[k].ed);
      chk($sformatf("R4 vec%0d parity", k), st_parity, VEC[k].epe);
      chk($sformatf("R5 vec%0d framing", k), st_framing, VEC[k].efe);
      chk($sformatf("R6 vec%0d no break", k), st_break, 0);
      pulse_ready();
      chk($sformatf("R7 vec%0d read empties", k), m_valid, 0);
      pulse_clr();
      chk($sformatf("R9 vec%0d clear", k), {st_parity, st_framing}, 0);
    end

    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_stick = 1'b0; cfg_stop2 = 1'b0;

    // R2 false start: short low glitch
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (48) @(negedge clk);
    chk("R2 glitch gives no word", m_valid, 0);
    send(8'h42, 1'b0, 1'b1, 1'b1);
    chk("R2 frame after glitch", m_data, 8'h42);
    pulse_ready();

    // R6 break: line low for longer than a frame
    rxd = 1'b0; repeat (14 * 16) @(negedge clk); rxd = 1'b1;
    repeat (48) @(negedge clk);
    chk("R6 break flag", st_break, 1);
    chk("R6 break framing", st_framing, 1);
    chk("R6 break word", m_data, 0);
    chk("R6 break valid", m_valid, 1);
    // R1: after the line rose and stays high nothing new starts
    pulse_ready(); pulse_clr();
    repeat (200) @(negedge clk);
    chk("R1 no frame on steady mark", m_valid, 0);

    // R8 overrun with held word under back-pressure
    send(8'h11, 1'b0, 1'b1, 1'b1);
    send(8'h22, 1'b0, 1'b1, 1'b1);
    chk("R8 overrun flag", st_overrun, 1);
    chk("R8 first word kept", m_data, 8'h11);
    chk("R7 still valid", m_valid, 1);
    pulse_ready();
    chk("R9 read keeps overrun", st_overrun, 1);
    pulse_clr();
    chk("R9 clear overrun", st_overrun, 0);

    // R10 slower tick doubles the bit time
    tdiv = 2;
    repeat (4) @(negedge clk);
    send(8'h9A, 1'b0, 1'b1, 1'b1);
    chk("R10 slow tick data", m_data, 8'h9A);
    chk("R10 slow tick valid", m_valid, 1);
    chk("R10 slow tick no error", {st_parity, st_framing}, 0);
    pulse_ready();

    finish_run();
  end
endmodule